// File: doc/BRIEF.md
# Multi-Width General Register File

This block is a bank of eight 32-bit general-purpose registers that an execution datapath reads and writes in three widths. Each physical register can be seen as a whole longword, as its upper or lower 16-bit half, or as either byte of its lower half. All of these views alias the same storage, so a narrow write to one view is visible through the wider views that overlap it.

Two combinational read ports deliver register-direct operand values. Each port takes a 3-bit register index, a 2-bit size code and one view-select bit. The value comes back zero-filled into the low bits of a 32-bit bus.

One synchronous write port takes the same three selectors. It merges the narrow data into the chosen slice on the rising clock edge and leaves every other bit untouched. An active-low asynchronous reset clears the whole bank. A read and a write to the same register in the same cycle returns the value held before the write, because nothing is forwarded.

Top module: `gpr_bank`

## Requirements
- R1: While reset is asserted and after it is released, every register reads as zero through every view on both ports.
- R2: Size code 2'b10 selects the longword view. A read returns all 32 bits of the indexed register, a write replaces all 32 bits with the write data, and the view-select bit is ignored.
- R3: Size code 2'b01 selects a word view. A read with the view-select bit at 0 returns bits 15:0 of the register, and with the bit at 1 it returns bits 31:16. In both cases the word appears in bits 15:0 of the bus and bits 31:16 of the bus are zero.
- R4: Size code 2'b00 selects a byte view. A read with the view-select bit at 0 returns bits 7:0 of the register, and with the bit at 1 it returns bits 15:8. In both cases the byte appears in bits 7:0 of the bus and bits 31:8 of the bus are zero.
- R5: A word write takes write-data bits 15:0. It stores them into bits 15:0 of the register when the view-select bit is 0, or into bits 31:16 when it is 1. The other half of that register keeps its value.
- R6: A byte write takes write-data bits 7:0. It stores them into bits 7:0 of the register when the view-select bit is 0, or into bits 15:8 when it is 1. The remaining 24 bits of that register keep their value.
- R7: A write of any size changes only the register named by the write index. The other seven registers keep their values.
- R8: Size code 2'b11 is reserved. A read with it returns zero, and a write with it changes no register.
- R9: A write takes effect at the rising clock edge. A read of the same register in the cycle of the write returns the old value, and the new value is returned from the following cycle onward.
- R10: The two read ports are independent. Each returns its own register and view in the same cycle, whatever the other port selects.
- R11: When the write enable is low, no register changes, whatever the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| rd_a_idx | input | 3 | Register index for read port A |
| rd_a_size | input | 2 | Size code for read port A (00 byte, 01 word, 10 longword, 11 reserved) |
| rd_a_hi | input | 1 | View select for port A: upper word or high byte when 1 |
| rd_a_data | output | 32 | Zero-filled operand value for port A |
| rd_b_idx | input | 3 | Register index for read port B |
| rd_b_size | input | 2 | Size code for read port B |
| rd_b_hi | input | 1 | View select for port B |
| rd_b_data | output | 32 | Zero-filled operand value for port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Register index for the write |
| wr_size | input | 2 | Size code for the write |
| wr_hi | input | 1 | View select for the write |
| wr_data | input | 32 | Write data; the low 8 or 16 bits are used for narrow writes |

## Verification
The read ports are combinational, so a corrupted slice shows up at the ports in the very cycle after the faulty write edge, once that register is read through any overlapping view. A bad merge, such as a byte write that clears its neighbours or that lands in the wrong half, is caught by reading back the whole longword of every register after each narrow write. The same readback also exposes a write that strays into another register. A view decoder that swaps halves or bytes, or leaves stale upper bits on the bus, is caught by sweeping every index, size code and view bit on both ports against the same arithmetic model.

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] rd_a_idx,
  input  logic [1:0]              rd_a_size,
  input  logic                    rd_a_hi,
  output logic [31:0]             rd_a_data,
  input  logic [$clog2(NREG)-1:0] rd_b_idx,
  input  logic [1:0]              rd_b_size,
  input  logic                    rd_b_hi,
  output logic [31:0]             rd_b_data,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [1:0]              wr_size,
  input  logic                    wr_hi,
  input  logic [31:0]             wr_data
);
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;

  logic [NREG-1:0][31:0] regs;

  function automatic logic [31:0] pick(input logic [31:0] r, input logic [1:0] sz, input logic hi);
    case (sz)
      SZ_BYTE: pick = {24'h0, hi ? r[15:8] : r[7:0]};
      SZ_WORD: pick = {16'h0, hi ? r[31:16] : r[15:0]};
      SZ_LONG: pick = r;
      default: pick = 32'h0;
    endcase
  endfunction

  assign rd_a_data = pick(regs[rd_a_idx], rd_a_size, rd_a_hi);
  assign rd_b_data = pick(regs[rd_b_idx], rd_b_size, rd_b_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_en) begin
      case (wr_size)
        SZ_BYTE: if (wr_hi) regs[wr_idx][15:8]  <= wr_data[7:0];
                 else       regs[wr_idx][7:0]   <= wr_data[7:0];
        SZ_WORD: if (wr_hi) regs[wr_idx][31:16] <= wr_data[15:0];
                 else       regs[wr_idx][15:0]  <= wr_data[15:0];
        SZ_LONG: regs[wr_idx] <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

module gpr_bank_chk #(
  parameter int NREG = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic [1:0]              wr_size,
  input logic                    wr_hi,
  input logic [31:0]             wr_data,
  input logic [$clog2(NREG)-1:0] rd_a_idx,
  input logic [1:0]              rd_a_size,
  input logic [31:0]             rd_a_data,
  input logic [NREG-1:0][31:0]   regs
);
  p_long_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b10) |=> regs[$past(wr_idx)] == $past(wr_data));

  p_long_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_size == 2'b10) |-> rd_a_data == regs[rd_a_idx]);

  p_word_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_size == 2'b01) |-> rd_a_data[31:16] == 16'h0);

  p_byte_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_size == 2'b00) |-> rd_a_data[31:8] == 24'h0);

  p_upper_word_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b01 && wr_hi) |=>
      regs[$past(wr_idx)][31:16] == $past(wr_data[15:0]) &&
      regs[$past(wr_idx)][15:0]  == $past(regs[wr_idx][15:0]));

  p_low_byte_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b00 && !wr_hi) |=>
      regs[$past(wr_idx)][7:0]  == $past(wr_data[7:0]) &&
      regs[$past(wr_idx)][31:8] == $past(regs[wr_idx][31:8]));

  p_reserved_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_size == 2'b11) |-> rd_a_data == 32'h0);

  p_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_size == 2'b11) |=> $stable(regs));
endmodule

bind gpr_bank gpr_bank_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
  .wr_hi(wr_hi), .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size),
  .rd_a_data(rd_a_data), .regs(regs)
);

// File: tb/gpr_bank_test.sv
module gpr_bank_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [1:0] rd_a_size = 0, rd_b_size = 0, wr_size = 0;
  logic rd_a_hi = 0, rd_b_hi = 0, wr_hi = 0, wr_en = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0;
  logic [31:0] model [8];
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gpr_bank uut (.*);

  function automatic logic [31:0] view(input logic [31:0] r, input logic [1:0] sz, input logic hi);
    if (sz == 2'd2) return r;
    if (sz == 2'd1) return hi ? (r >> 16) : (r & 32'hFFFF);
    if (sz == 2'd0) return hi ? ((r >> 8) & 32'hFF) : (r & 32'hFF);
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [1:0] sz);
    case (sz)
      2'd0: return "R4";
      2'd1: return "R3";
      2'd2: return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] i, input logic [1:0] sz, input logic hi, input logic [31:0] d);
    case (sz)
      2'd0: if (hi) model[i][15:8] = d[7:0]; else model[i][7:0] = d[7:0];
      2'd1: if (hi) model[i][31:16] = d[15:0]; else model[i][15:0] = d[15:0];
      2'd2: model[i] = d;
      default: ;
    endcase
  endtask

  task automatic write(input logic [2:0] i, input logic [1:0] sz, input logic hi, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = i; wr_size = sz; wr_hi = hi; wr_data = d;
    @(posedge clk);
    #1 wr_en = 0;
    apply(i, sz, hi, d);
  endtask

  task automatic read_all_long(input string tag);
    for (int i = 0; i < 8; i++) begin
      rd_a_idx = 3'(i); rd_a_size = 2'd2; rd_a_hi = 0;
      #1 check(tag, rd_a_data, model[i]);
    end
  endtask

  task automatic sweep(input string extra);
    for (int i = 0; i < 8; i++)
      for (int s = 0; s < 4; s++)
        for (int h = 0; h < 2; h++) begin
          rd_a_idx = 3'(i); rd_a_size = 2'(s); rd_a_hi = h[0];
          rd_b_idx = 3'(7 - i); rd_b_size = 2'(3 - s); rd_b_hi = ~h[0];
          #1;
          check({tag_of(2'(s)), extra, " A"}, rd_a_data, view(model[i], 2'(s), h[0]));
          check({tag_of(2'(3 - s)), extra, " B R10"}, rd_b_data, view(model[7 - i], 2'(3 - s), ~h[0]));
        end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    #25;
    sweep(" R1 in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    sweep(" R1 after reset");

    for (int i = 0; i < 8; i++)
      write(3'(i), 2'd2, i[0], 32'hA0B1C2D3 ^ (32'h11111111 * i));
    sweep(" long pattern");

    for (int i = 0; i < 8; i++) begin
      write(3'(i), 2'd1, 1'b1, 32'hFFFF0000 | (16'h5A00 + 16'(i)));
      read_all_long("R5 R7 upper word");
      write(3'(i), 2'd1, 1'b0, 32'h12340000 | (16'hC300 + 16'(i)));
      read_all_long("R5 R7 lower word");
      write(3'(i), 2'd0, 1'b1, 32'hFFFFFF00 | (8'h70 + 8'(i)));
      read_all_long("R6 R7 high byte");
      write(3'(i), 2'd0, 1'b0, 32'h87654300 | (8'hE0 + 8'(i)));
      read_all_long("R6 R7 low byte");
    end
    sweep(" after merges");

    write(3'd4, 2'd3, 1'b0, 32'hDEADBEEF);
    write(3'd5, 2'd3, 1'b1, 32'h0BADF00D);
    read_all_long("R8 reserved write");

    @(negedge clk);
    wr_en = 0; wr_idx = 3'd2; wr_size = 2'd2; wr_data = 32'hCAFEBABE;
    @(posedge clk); #1;
    read_all_long("R11 enable low");

    @(negedge clk);
    wr_en = 1; wr_idx = 3'd6; wr_size = 2'd2; wr_hi = 0; wr_data = 32'h13579BDF;
    rd_a_idx = 3'd6; rd_a_size = 2'd2; rd_a_hi = 0;
    #2 check("R9 same cycle old", rd_a_data, model[6]);
    @(posedge clk); #1 wr_en = 0;
    model[6] = 32'h13579BDF;
    check("R9 next cycle new", rd_a_data, 32'h13579BDF);

    rd_a_idx = 3'd6; rd_a_size = 2'd1; rd_a_hi = 1;
    rd_b_idx = 3'd6; rd_b_size = 2'd0; rd_b_hi = 0;
    #1;
    check("R10 A word hi", rd_a_data, 32'h1357);
    check("R10 B byte lo", rd_b_data, 32'hDF);

    @(negedge clk); rst_n = 0;
    for (int i = 0; i < 8; i++) model[i] = 0;
    #1 read_all_long("R1 reset again");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule